// File: doc/BRIEF.md
# Burst Address Counter

This block is the address register for one port of a synchronous memory. It runs on that port's clock. On each rising edge it picks one action from three active-low controls and presents the result as the internal address for the memory array. The three controls are an address strobe, a count enable and a counter clear. The actions are:

- take the external address,
- step to the next word,
- return to zero,
- keep the current value.

A burst begins by strobing in a start address. Holding count enable low then walks through successive words, one per clock. The counter covers the full address space and rolls over from the highest address to zero. The controls have a fixed priority: the clear wins over the strobe, and the strobe wins over count enable. The address width is a parameter and takes the values 15, 16 or 17.

Top module: `burst_addr_counter`

## Requirements
- R1: While the synchronous active-high `rst` is high at a rising edge, the address output is zero in the following cycle.
- R2: With `clear_n` high and `strobe_n` low at a rising edge, the address output equals the `ext_addr` value sampled at that edge, starting in the following cycle.
- R3: With `clear_n` and `strobe_n` high and `count_en_n` low at a rising edge, the address output becomes the previous output plus one in the following cycle.
- R4: With `clear_n` low at a rising edge, the address output becomes zero in the following cycle, whatever `strobe_n`, `count_en_n` and `ext_addr` are.
- R5: While `strobe_n` is low, `count_en_n` has no effect: the output is the loaded address and is not that address plus one.
- R6: Incrementing from the all-ones address (2^AW − 1) gives zero.
- R7: With `clear_n`, `strobe_n` and `count_en_n` all high at a rising edge, the address output keeps its value in the following cycle, and `ext_addr` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| ext_addr | input | AW | Externally supplied address, taken when the strobe is low |
| strobe_n | input | 1 | Active-low address strobe (load) |
| count_en_n | input | 1 | Active-low count enable (increment) |
| clear_n | input | 1 | Active-low counter clear |
| addr_out | output | AW | Registered internal address for the memory array |

## Verification
The rollover from the all-ones address to zero is the hardest case to reach from the ports. Counting up from zero would take 32768 or more cycles, and random stimulus almost never lands on that address. The bench therefore strobes in addresses next to the top of the range and then asserts count enable for a few cycles to cross the boundary. It also drives all three controls low together, and strobe plus count enable together, so that each priority decision is exercised against the other controls.

// File: rtl/burst_pkg.sv
package burst_pkg;

    // Action selected for one clock edge
    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_INC   = 2'd1,
        OP_LOAD  = 2'd2,
        OP_CLEAR = 2'd3
    } cnt_op_e;

    // Control requests after polarity conversion (active high)
    typedef struct packed {
        logic clear;
        logic load;
        logic inc;
    } cnt_req_t;

    // Fixed priority: clear over load over increment
    function automatic cnt_op_e pick_op(input cnt_req_t req);
        if (req.clear)     return OP_CLEAR;
        else if (req.load) return OP_LOAD;
        else if (req.inc)  return OP_INC;
        else               return OP_HOLD;
    endfunction

endpackage

// File: rtl/burst_op_decode.sv
module burst_op_decode
    import burst_pkg::*;
(
    input  logic    strobe_n,
    input  logic    count_en_n,
    input  logic    clear_n,
    output cnt_op_e op
);
    cnt_req_t req;

    always_comb begin
        req.clear = ~clear_n;
        req.load  = ~strobe_n;
        req.inc   = ~count_en_n;
        op        = pick_op(req);
    end
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
    import burst_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  cnt_op_e       op,
    input  logic [AW-1:0] load_val,
    output logic [AW-1:0] q
);
    localparam logic [AW-1:0] ZERO = '0;
    localparam logic [AW-1:0] STEP = AW'(1);

    logic [AW-1:0] nxt;

    always_comb begin
        unique case (op)
            OP_CLEAR: nxt = ZERO;
            OP_LOAD:  nxt = load_val;
            OP_INC:   nxt = q + STEP;   // natural modulo-2^AW rollover
            default:  nxt = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= ZERO;
        else     q <= nxt;
    end

    assert_inc_step_R3: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC) |=> (q == $past(q) + STEP));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(q));

    assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (op == OP_INC && q == {AW{1'b1}}) |=> (q == ZERO));
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
    import burst_pkg::*;
#(
    parameter int AW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ext_addr,
    input  logic          strobe_n,
    input  logic          count_en_n,
    input  logic          clear_n,
    output logic [AW-1:0] addr_out
);
    cnt_op_e op;

    burst_op_decode u_dec (
        .strobe_n   (strobe_n),
        .count_en_n (count_en_n),
        .clear_n    (clear_n),
        .op         (op)
    );

    burst_addr_reg #(.AW(AW)) u_reg (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .load_val (ext_addr),
        .q        (addr_out)
    );

    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (rst)
        !clear_n |=> (addr_out == '0));

    assert_load_value_R2: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !strobe_n) |=> (addr_out == $past(ext_addr)));

    assert_load_beats_count_R5: assert property (@(posedge clk) disable iff (rst)
        (clear_n && !strobe_n && !count_en_n) |=> (addr_out == $past(ext_addr)));

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (addr_out == '0));
endmodule

// File: tb/burst_addr_counter_tb.sv
`timescale 1ns/1ps
module burst_addr_counter_tb;
    localparam int AW = 15;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ext_addr = '0;
    logic          strobe_n = 1'b1;
    logic          count_en_n = 1'b1;
    logic          clear_n = 1'b1;
    logic [AW-1:0] addr_out;

    int n_checks = 0;
    int n_fail   = 0;
    logic [AW-1:0] exp_addr = '0;

    always #5 clk = ~clk;

    burst_addr_counter #(.AW(AW)) u_dut (
        .clk(clk), .rst(rst), .ext_addr(ext_addr), .strobe_n(strobe_n),
        .count_en_n(count_en_n), .clear_n(clear_n), .addr_out(addr_out)
    );

    // Reference model from the requirements
    function automatic logic [AW-1:0] model(input logic [AW-1:0] cur,
        input logic [AW-1:0] ext, input logic s_n, input logic c_n, input logic k_n);
        if (!k_n)      return '0;
        else if (!s_n) return ext;
        else if (!c_n) return cur + AW'(1);
        else           return cur;
    endfunction

    function automatic string req_of(input logic s_n, input logic c_n,
        input logic k_n, input logic [AW-1:0] cur);
        if (!k_n)                   return "R4";
        else if (!s_n && !c_n)      return "R5";
        else if (!s_n)              return "R2";
        else if (!c_n && cur == TOP) return "R6";
        else if (!c_n)              return "R3";
        else                        return "R7";
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] exp);
        n_checks++;
        if (addr_out !== exp) begin
            n_fail++;
            $display("FAIL %s: addr_out=%0h expected=%0h", req, addr_out, exp);
        end
    endtask

    // Apply one cycle of controls at negedge, check at the following negedge
    task automatic step(input logic [AW-1:0] ext, input logic s_n,
                        input logic c_n, input logic k_n);
        string r;
        r = req_of(s_n, c_n, k_n, exp_addr);
        ext_addr = ext; strobe_n = s_n; count_en_n = c_n; clear_n = k_n;
        exp_addr = model(exp_addr, ext, s_n, c_n, k_n);
        @(negedge clk);
        chk(r, exp_addr);
    endtask

    logic done = 1'b0;

    initial begin
        #1000000;
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R1", '0);                       // R1: reset state
        rst = 1'b0;
        exp_addr = '0;

        step(15'h1234, 1'b0, 1'b1, 1'b1);    // R2 load
        step(15'h7777, 1'b1, 1'b1, 1'b1);    // R7 hold, ext ignored
        step('0,       1'b1, 1'b0, 1'b1);    // R3 increment
        step('0,       1'b1, 1'b0, 1'b1);    // R3
        step(15'h0100, 1'b0, 1'b0, 1'b1);    // R5 load beats count
        step(TOP - 15'd1, 1'b0, 1'b1, 1'b1); // R2 near top
        step('0,       1'b1, 1'b0, 1'b1);    // R3 to top
        step('0,       1'b1, 1'b0, 1'b1);    // R6 wrap to zero
        step('0,       1'b1, 1'b0, 1'b1);    // R3 from zero
        step(15'h2222, 1'b0, 1'b0, 1'b0);    // R4 clear beats all
        step(15'h3333, 1'b0, 1'b1, 1'b1);    // R2
        step(15'h4444, 1'b1, 1'b0, 1'b0);    // R4 clear beats count
        step(TOP,      1'b0, 1'b0, 1'b1);    // R5 load top with count low
        step('0,       1'b1, 1'b0, 1'b1);    // R6 wrap

        // R1 again mid-run
        rst = 1'b1; clear_n = 1'b1; strobe_n = 1'b0; ext_addr = 15'h5555;
        @(negedge clk);
        chk("R1", '0);
        rst = 1'b0; exp_addr = '0;

        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] e;
            logic s, c, k;
            int sel;
            sel = $urandom_range(0, 9);
            e = (sel == 0) ? TOP - AW'($urandom_range(0, 2)) : AW'($urandom);
            s = ($urandom_range(0, 3) != 0);
            c = ($urandom_range(0, 2) == 0);
            k = ($urandom_range(0, 9) != 0);
            step(e, s, c, k);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule